// File: doc/BRIEF.md
# Edge Capture Counter and Timer

This block watches one external input that has already been brought into the clock domain. It has two modes, and both use the same 24-bit counter.

- **Edge-count mode:** each qualifying edge of the input steps the counter once. When the counter lands on a programmed match value, a sticky match flag rises and the counter stops.
- **Edge-time mode:** the counter runs on every clock, wrapping between zero and a programmed load value. Each qualifying edge copies the counter into a capture register and raises a sticky event flag.

The counter can count down (the default) or up. The edge that qualifies is chosen by a 2-bit select: rising only, falling only, or either.

The counter is 16 bits plus an 8-bit extension. The extension sits above the 16 low bits, so load, match, count and capture values are all 24 bits wide, with the extension as the upper byte. Software starts the counter with a start strobe and can halt it with a stop strobe. It clears the flags by writing ones to a clear input.

Top module: `ecap_top`

## Requirements
- R1: After reset the count, the captured value, both flags and the running state are all zero.
- R2: Edge select 2'b00 qualifies rising edges only, 2'b01 qualifies falling edges only, and 2'b10 or 2'b11 qualifies both edges.
- R3: An edge is recognised in the first clock where the sampled input differs from the sample of the previous clock. The count or capture register holds the new value right after that clock edge.
- R4: With the down direction (`dir_up_i`=0), a start strobe loads the count with the 24-bit load value and sets running. Each qualifying edge in edge-count mode (`mode_i`=0) then decrements the count by one.
- R5: With the up direction (`dir_up_i`=1), a start strobe loads zero and sets running. Each qualifying edge in edge-count mode then increments the count by one.
- R6: In edge-count mode, an edge that moves the count onto the match value sets the match flag (`flags_o` bit 1) and clears running. Later edges leave the count unchanged.
- R7: The match comparison uses all 24 bits. Borrows and carries cross from the low 16 bits into the 8-bit extension. A count whose low 16 bits match but whose extension differs does not set the match flag.
- R8: In edge-time mode (`mode_i`=1) the running counter steps once per clock. Down-counting wraps from 0 to the load value; up-counting wraps from the load value to 0.
- R9: In edge-time mode, a qualifying edge copies the counter value of that clock (before its step) into the capture register and sets the event flag (`flags_o` bit 0). A later edge overwrites the earlier capture.
- R10: Both flags stay set until a 1 is written to their bit of `clr_i` (bit 0 clears the event flag, bit 1 the match flag). A set and a clear in the same clock leave the flag set.
- R11: A stop strobe clears running. While the block is not running the count does not move, and edges neither capture nor count.
- R12: Edge-count mode never sets the event flag. Edge-time mode never sets the match flag, even when the counter passes through the match value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 1 | Synchronized input pin; must be low during reset |
| mode_i | input | 1 | 0 = edge count, 1 = edge time |
| dir_up_i | input | 1 | 0 = count down, 1 = count up |
| edge_sel_i | input | 2 | 00 rising, 01 falling, 1x both edges |
| load_i | input | 16 | Load value, low bits |
| load_ext_i | input | 8 | Load value, extension bits (upper byte) |
| match_i | input | 16 | Match value, low bits |
| match_ext_i | input | 8 | Match value, extension bits (upper byte) |
| start_i | input | 1 | Load the counter and set running |
| stop_i | input | 1 | Clear running |
| clr_i | input | 2 | Write-1-to-clear: bit 0 event flag, bit 1 match flag |
| cap_o | output | 24 | Last captured counter value |
| count_o | output | 24 | Current counter value |
| running_o | output | 1 | Counter enabled |
| flags_o | output | 2 | Bit 0 event flag, bit 1 match flag |

## Verification
The bench walks edge patterns through every edge-select setting. A wrong polarity decode would give a count that differs from the number of rising, falling or total transitions. It drives a down count across the 16-bit boundary with match values that differ only in the extension byte. A comparator that looks only at the low half would then raise a false match flag. It also checks the wrap point of the free-running counter in both directions, and the exact value captured on an edge, where a one-clock skew would show as an off-by-one capture. Finally it applies a clear in the same clock as an event, where a design giving priority to the clear would drop the flag.

// File: rtl/ecap_pkg.sv
package ecap_pkg;
  localparam logic MODE_COUNT = 1'b0;
  localparam logic MODE_TIME  = 1'b1;
  localparam int   FLAG_EVT   = 0;
  localparam int   FLAG_MAT   = 1;
  localparam int   NUM_FLAGS  = 2;

  // Decide whether the transition prev -> cur qualifies under the select.
  function automatic logic edge_qualifies(logic [1:0] sel, logic prev, logic cur);
    if (sel[1])      return prev ^ cur;
    else if (sel[0]) return prev & ~cur;
    else             return ~prev & cur;
  endfunction
endpackage

// File: rtl/ecap_edge_det.sv
module ecap_edge_det
  import ecap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_i,
  input  logic [1:0] sel_i,
  output logic       edge_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= pin_i;
  end

  assign edge_o = edge_qualifies(sel_i, prev_q, pin_i);

  // R3: an edge is only seen when the sample changed
  a_r3_edge_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |-> (pin_i != prev_q));
endmodule

// File: rtl/ecap_flags.sv
module ecap_flags
  import ecap_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_FLAGS-1:0] set_i,
  input  logic [NUM_FLAGS-1:0] clr_i,
  output logic [NUM_FLAGS-1:0] flags_o
);
  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flags_o[g] <= 1'b0;
      else if (set_i[g]) flags_o[g] <= 1'b1;
      else if (clr_i[g]) flags_o[g] <= 1'b0;
    end

    // R10: a set wins over a clear in the same clock
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[g] |=> flags_o[g]);
    // R10: without a clear the flag holds
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_o[g] && !clr_i[g]) |=> flags_o[g]);
  end
endmodule

// File: rtl/ecap_counter.sv
module ecap_counter
  import ecap_pkg::*;
#(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode_i,
  input  logic         up_i,
  input  logic [W-1:0] load_i,
  input  logic [W-1:0] match_i,
  input  logic         start_i,
  input  logic         stop_i,
  input  logic         edge_i,
  output logic [W-1:0] count_o,
  output logic [W-1:0] cap_o,
  output logic         running_o,
  output logic         match_hit_o,
  output logic         cap_hit_o
);
  // Next counter value with wrap between 0 and the load value.
  function automatic logic [W-1:0] step_val(logic [W-1:0] cur, logic [W-1:0] lim, logic up);
    if (up) return (cur == lim) ? '0 : cur + 1'b1;
    else    return (cur == '0) ? lim : cur - 1'b1;
  endfunction

  logic [W-1:0] nxt;
  logic         cnt_evt, time_tick;

  assign nxt         = step_val(count_o, load_i, up_i);
  assign cnt_evt     = running_o && (mode_i == MODE_COUNT) && edge_i;
  assign time_tick   = running_o && (mode_i == MODE_TIME);
  assign match_hit_o = cnt_evt && (nxt == match_i);
  assign cap_hit_o   = time_tick && edge_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_o   <= '0;
      running_o <= 1'b0;
    end else if (start_i) begin
      count_o   <= up_i ? '0 : load_i;
      running_o <= 1'b1;
    end else if (stop_i) begin
      running_o <= 1'b0;
    end else if (cnt_evt) begin
      count_o <= nxt;
      if (match_hit_o) running_o <= 1'b0;
    end else if (time_tick) begin
      count_o <= nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cap_o <= '0;
    else if (cap_hit_o) cap_o <= count_o;
  end

  // R6: reaching the match stops the counter
  a_r6_stop_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    (match_hit_o && !start_i) |=> !running_o);
  // R11: idle counter does not move
  a_r11_idle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!running_o && !start_i) |=> $stable(count_o));
  // R9: capture takes the pre-step counter value
  a_r9_capture_value: assert property (@(posedge clk) disable iff (!rst_n)
    cap_hit_o |=> (cap_o == $past(count_o)));
  // R5: up start begins at zero
  a_r5_up_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && up_i) |=> (count_o == '0));
  // R4: down start begins at the load value
  a_r4_down_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !up_i) |=> (count_o == $past(load_i)));
endmodule

// File: rtl/ecap_top.sv
module ecap_top
  import ecap_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int EXT_W = 8,
  localparam int TOT_W = CNT_W + EXT_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pin_i,
  input  logic                 mode_i,
  input  logic                 dir_up_i,
  input  logic [1:0]           edge_sel_i,
  input  logic [CNT_W-1:0]     load_i,
  input  logic [EXT_W-1:0]     load_ext_i,
  input  logic [CNT_W-1:0]     match_i,
  input  logic [EXT_W-1:0]     match_ext_i,
  input  logic                 start_i,
  input  logic                 stop_i,
  input  logic [NUM_FLAGS-1:0] clr_i,
  output logic [TOT_W-1:0]     cap_o,
  output logic [TOT_W-1:0]     count_o,
  output logic                 running_o,
  output logic [NUM_FLAGS-1:0] flags_o
);
  logic                 edge_w, match_hit_w, cap_hit_w;
  logic [NUM_FLAGS-1:0] set_w;

  ecap_edge_det u_edge (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .sel_i(edge_sel_i), .edge_o(edge_w)
  );

  ecap_counter #(.W(TOT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .up_i(dir_up_i),
    .load_i({load_ext_i, load_i}), .match_i({match_ext_i, match_i}),
    .start_i(start_i), .stop_i(stop_i), .edge_i(edge_w),
    .count_o(count_o), .cap_o(cap_o), .running_o(running_o),
    .match_hit_o(match_hit_w), .cap_hit_o(cap_hit_w)
  );

  assign set_w[FLAG_EVT] = cap_hit_w;
  assign set_w[FLAG_MAT] = match_hit_w;

  ecap_flags u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(set_w), .clr_i(clr_i), .flags_o(flags_o)
  );

  // R12: the mode selects which flag may be raised
  a_r12_flag_by_mode: assert property (@(posedge clk) disable iff (!rst_n)
    !(cap_hit_w && match_hit_w));
endmodule

// File: tb/ecap_top_tb.sv
module ecap_top_tb;
  import ecap_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin_i = 1'b0;
  logic        mode_i = 1'b0;
  logic        dir_up_i = 1'b0;
  logic [1:0]  edge_sel_i = 2'b00;
  logic [15:0] load_i = '0;
  logic [7:0]  load_ext_i = '0;
  logic [15:0] match_i = '0;
  logic [7:0]  match_ext_i = '0;
  logic        start_i = 1'b0;
  logic        stop_i = 1'b0;
  logic [1:0]  clr_i = '0;
  logic [23:0] cap_o, count_o;
  logic        running_o;
  logic [1:0]  flags_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ecap_top u_dut (.*);

  // {edge select, pin sequence applied LSB first, expected edge count}
  localparam logic [17:0] VEC [7] = '{
    {2'b00, 8'h55, 8'd4},
    {2'b01, 8'h55, 8'd4},
    {2'b10, 8'h55, 8'd8},
    {2'b11, 8'h0F, 8'd2},
    {2'b00, 8'hFF, 8'd1},
    {2'b01, 8'h0F, 8'd1},
    {2'b00, 8'h33, 8'd2}
  };

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(string req, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse();
    pin_i = 1'b1; tick(); pin_i = 1'b0; tick();
  endtask

  task automatic start();
    start_i = 1'b1; tick(); start_i = 1'b0;
  endtask

  task automatic halt();
    stop_i = 1'b1; tick(); stop_i = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    // R1 reset state
    chk("R1 count", count_o, 24'h0);
    chk("R1 cap", cap_o, 24'h0);
    chk("R1 flags+run", {21'h0, flags_o, running_o}, 24'h0);
    rst_n = 1'b1;
    tick();

    // R2 R3 R5: edge patterns, up count from zero
    mode_i = MODE_COUNT; dir_up_i = 1'b1;
    load_i = 16'hFFFF; load_ext_i = 8'hFF; match_i = 16'hFFFF; match_ext_i = 8'hFF;
    for (int v = 0; v < 7; v++) begin
      halt(); pin_i = 1'b0; tick();
      edge_sel_i = VEC[v][17:16];
      start();
      chk("R5 start zero", count_o, 24'h0);
      for (int b = 0; b < 8; b++) begin
        pin_i = VEC[v][8 + b]; tick();
      end
      chk("R2 edge count", count_o, {16'h0, VEC[v][7:0]});
    end
    // R3: count moves in the clock the changed sample is taken
    halt(); pin_i = 1'b0; tick(); edge_sel_i = 2'b00; start();
    pin_i = 1'b1; tick();
    chk("R3 same clock", count_o, 24'h1);
    pin_i = 1'b0; tick();

    // R4 R6: down count to match
    halt(); dir_up_i = 1'b0;
    load_i = 16'd16; load_ext_i = 8'h0; match_i = 16'd12; match_ext_i = 8'h0;
    start();
    chk("R4 load", count_o, 24'd16);
    repeat (3) pulse();
    chk("R4 down count", count_o, 24'd13);
    chk("R6 no flag yet", {23'h0, flags_o[FLAG_MAT]}, 24'h0);
    pulse();
    chk("R6 at match", count_o, 24'd12);
    chk("R6 flag", {23'h0, flags_o[FLAG_MAT]}, 24'h1);
    chk("R6 stopped", {23'h0, running_o}, 24'h0);
    pulse();
    chk("R6 count held", count_o, 24'd12);
    chk("R12 no event in count mode", {23'h0, flags_o[FLAG_EVT]}, 24'h0);

    // R7: borrow across extension, extension-only mismatch
    clr_i = 2'b10; tick(); clr_i = 2'b00;
    load_i = 16'h0001; load_ext_i = 8'h01; match_i = 16'hFFFF; match_ext_i = 8'h02;
    start();
    pulse();
    chk("R7 borrow", count_o, 24'h010000);
    pulse();
    chk("R7 extension", count_o, 24'h00FFFF);
    chk("R7 no partial match", {22'h0, flags_o[FLAG_MAT], running_o}, 24'h1);
    halt(); match_ext_i = 8'h00; start();
    pulse(); pulse();
    chk("R7 full match", {22'h0, flags_o[FLAG_MAT], running_o}, 24'h2);

    // R8: time mode wrap, down then up
    mode_i = MODE_TIME; load_i = 16'd5; load_ext_i = 8'h0; match_i = 16'd3;
    clr_i = 2'b10; tick(); clr_i = 2'b00;
    start();
    chk("R8 down load", count_o, 24'd5);
    repeat (5) tick();
    chk("R8 down zero", count_o, 24'd0);
    tick();
    chk("R8 down wrap", count_o, 24'd5);
    repeat (3) tick();
    chk("R12 no match in time mode", {23'h0, flags_o[FLAG_MAT]}, 24'h0);
    halt(); dir_up_i = 1'b1; load_i = 16'd3; start();
    repeat (3) tick();
    chk("R8 up top", count_o, 24'd3);
    tick();
    chk("R8 up wrap", count_o, 24'd0);

    // R9: capture value and overwrite
    halt(); dir_up_i = 1'b0; load_i = 16'h0100; edge_sel_i = 2'b00; start();
    repeat (10) tick();
    chk("R9 pre", count_o, 24'h0000F6);
    pin_i = 1'b1; tick();
    chk("R9 capture", cap_o, 24'h0000F6);
    chk("R9 event", {23'h0, flags_o[FLAG_EVT]}, 24'h1);
    pin_i = 1'b0; tick();
    chk("R9 falling ignored", cap_o, 24'h0000F6);
    pin_i = 1'b1; tick();
    chk("R9 overwrite", cap_o, 24'h0000F4);

    // R10: set beats clear, then clear works
    pin_i = 1'b0; tick();
    pin_i = 1'b1; clr_i = 2'b01; tick(); clr_i = 2'b00;
    chk("R10 set wins", {23'h0, flags_o[FLAG_EVT]}, 24'h1);
    clr_i = 2'b01; tick(); clr_i = 2'b00;
    chk("R10 cleared", {23'h0, flags_o[FLAG_EVT]}, 24'h0);

    // R11: stopped counter ignores time and edges
    pin_i = 1'b0; halt();
    begin
      logic [23:0] held, hcap;
      held = count_o; hcap = cap_o;
      repeat (3) tick();
      chk("R11 count held", count_o, held);
      pin_i = 1'b1; tick();
      chk("R11 no capture", cap_o, hcap);
      chk("R11 no event", {23'h0, flags_o[FLAG_EVT]}, 24'h0);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule